// File: doc/BRIEF.md
# Reset and Mute Sequencer for a Mixed-Signal Audio Device

This block decides which parts of an audio device are held in reset and when the DAC outputs may play. It has two reset depths. The external active-low reset pin is the deep one. While the pin is low the whole device is reset, the device is in low-power mode, and the codec and DSP are held in reset with the outputs muted. The pin must be held low from power-up until the supplies settle. The shallow depth is a brownout, reported by an undervoltage flag from an analog comparator outside this block. A brownout resets the codec only, asks the DSP for a soft reset and mutes the outputs. The control port and the registers keep their state.

Leaving a codec reset goes through a fixed recovery. The DSP receives a one-cycle restart pulse so that it reruns its application code. The codec is then given time to resynchronize, and the outputs stay muted until the codec reports lock. If lock does not arrive within a timeout, the codec is reset again. The pin has priority over the undervoltage flag. The flag is filtered so that short dips on the supply do not interrupt playback.

Top module: `rstmute_ctrl`

## Requirements
- R1: While `ext_rst_n` is low, without waiting for a clock edge: `full_rst_n`=0, `low_power`=1, `codec_rst`=1, `dsp_soft_rst`=1, `dac_mute`=1 and `dsp_restart`=0.
- R2: After `ext_rst_n` rises, `full_rst_n` stays 0 after the first rising clock edge and becomes 1 after the second. `low_power` falls in the same cycle. Once released, it stays released while the pin is high.
- R3: `uv_detect` (1 = undervoltage) passes through two synchronizing flops and then takes effect only after UV_DEBOUNCE consecutive high samples. A high pulse of UV_DEBOUNCE-1 clock samples has no effect: `codec_rst` and `dac_mute` stay 0 during playback.
- R4: An undervoltage held for UV_DEBOUNCE samples sets `codec_rst`, `dsp_soft_rst` and `dac_mute` to 1 after UV_DEBOUNCE+3 edges, counted from the first edge that samples it high. `full_rst_n` stays 1 and `low_power` stays 0.
- R5: Codec reset lasts while the filtered undervoltage is high, and for CODEC_HOLD further cycles after it clears. Clearing also needs UV_DEBOUNCE consecutive low samples. `dsp_restart` appears UV_DEBOUNCE+2+CODEC_HOLD edges after the first low sample.
- R6: Leaving codec reset raises `dsp_restart` for exactly one cycle and drops `codec_rst` and `dsp_soft_rst`, while `dac_mute` stays 1. After a pin release this happens 2+CODEC_HOLD edges after the pin rises.
- R7: During resynchronization, `codec_lock`=1 sampled at an edge clears `dac_mute` after that edge.
- R8: If `codec_lock` stays 0 for LOCK_TIMEOUT edges after the restart pulse, `codec_rst` returns to 1 after the LOCK_TIMEOUT-th edge.
- R9: An undervoltage that comes and goes while the pin is low has no effect. The outputs keep their reset values, and recovery after the pin rises takes the same 2+CODEC_HOLD edges.
- R10: `dac_mute` is 1 in every cycle in which the full reset, the codec reset or resynchronization is active, and 0 only during lock-confirmed playback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| uv_detect | input | 1 | Undervoltage flag from the supply comparator, active high, asynchronous |
| codec_lock | input | 1 | Codec reports it has resynchronized (synchronous to clk) |
| full_rst_n | output | 1 | Whole-device reset, active low |
| low_power | output | 1 | Low-power mode enable |
| codec_rst | output | 1 | Codec reset, active high |
| dsp_soft_rst | output | 1 | DSP soft-reset request, active high |
| dsp_restart | output | 1 | One-cycle pulse: DSP reruns its application code |
| dac_mute | output | 1 | DAC output mute, active high |

## Verification
The reference model follows the pin release, the debounce filter and the recovery phases, and every output is compared against it on every cycle. The stimulus covers the following cases:
- A pin release with no undervoltage, which gives the baseline recovery time.
- An undervoltage pulse one sample too short, which tells filtering apart from triggering.
- A held brownout followed by its release, which separates the two reset depths and measures the debounce on the way out.
- A resync in which lock never arrives, which checks the timeout path against the lock path.
- A brownout during a pin reset, followed by a recovery that must match the baseline. This shows that pin priority leaves nothing behind.

// File: rtl/rstmute_pkg.sv
// Package: shared types for the reset and mute sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package rstmute_pkg;

    // Recovery phase of the codec domain. Full-chip reset is not a phase:
    // it overrides every phase from the synchronized pin reset.
    typedef enum logic [1:0] {
        PH_CRST   = 2'd0,   // codec held in reset, DSP soft reset requested
        PH_RESYNC = 2'd1,   // codec released, waiting for lock, still muted
        PH_RUN    = 2'd2    // lock confirmed, outputs playing
    } phase_e;

endpackage

// File: rtl/rstmute_rsync.sv
// Module: reset pin synchronizer.
// Does: turns the asynchronous active-low pin into an internal active-low
//       reset that asserts at once and releases after STAGES clock edges.
// Assumes: STAGES >= 2; the pin may change at any time relative to clk.
module rstmute_rsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic pin_n,
    output logic rst_n_o
);

    logic [STAGES-1:0] chain_q;

    // Purpose: async clear on the pin, shift ones in once it is released.
    always_ff @(posedge clk or negedge pin_n) begin
        if (!pin_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], 1'b1};
        end
    end

    assign rst_n_o = chain_q[STAGES-1];

    // Once released, the internal reset does not drop again while the pin is high.
    p_release_sticky_r2: assert property (@(posedge clk) disable iff (!pin_n)
        rst_n_o |=> rst_n_o);

endmodule

// File: rtl/rstmute_uvfilt.sv
// Module: undervoltage synchronizer and debounce filter.
// Does: samples the raw comparator flag through two flops, then changes the
//       filtered level only after DEPTH consecutive samples of the new value.
// Assumes: rst_n is synchronous active-low; DEPTH >= 1.
module rstmute_uvfilt #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_raw,
    output logic uv_flt
);

    localparam int CW = $clog2(DEPTH + 1);

    logic          s1_q;
    logic          s2_q;
    logic [CW-1:0] run_q;
    logic          flt_q;

    // Purpose: bring the asynchronous flag into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= uv_raw;
            s2_q <= s1_q;
        end
    end

    // Purpose: count consecutive disagreeing samples and flip the level at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            flt_q <= 1'b0;
        end else if (s2_q == flt_q) begin
            run_q <= '0;
        end else if (run_q == CW'(DEPTH - 1)) begin
            flt_q <= s2_q;
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assign uv_flt = flt_q;

    // The filtered flag only rises after the synchronized sample was high.
    p_flt_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flt_q) |-> $past(s2_q));

    // The run counter never reaches DEPTH.
    p_run_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run_q < CW'(DEPTH));

endmodule

// File: rtl/rstmute_seq.sv
// Module: codec-domain recovery sequencer.
// Does: holds the codec in reset while undervoltage is present and for HOLD
//       cycles after it, pulses a DSP restart on release, then waits for codec
//       lock (up to TIMEOUT cycles) before allowing playback.
// Assumes: rst_n is the synchronized full-chip reset (synchronous active-low);
//          codec_lock is synchronous to clk; HOLD >= 1, TIMEOUT >= 1.
module rstmute_seq
    import rstmute_pkg::*;
#(
    parameter int HOLD    = 3,
    parameter int TIMEOUT = 16
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   uv_flt,
    input  logic   codec_lock,
    output phase_e phase_o,
    output logic   restart_o
);

    localparam int HW = $clog2(HOLD + 1);
    localparam int TW = $clog2(TIMEOUT + 1);

    phase_e        phase_q;
    logic [HW-1:0] hold_q;
    logic [TW-1:0] wait_q;
    logic          restart_q;

    // Purpose: phase transitions, hold and lock-wait counters, restart pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_CRST;
            hold_q    <= '0;
            wait_q    <= '0;
            restart_q <= 1'b0;
        end else begin
            restart_q <= 1'b0;
            case (phase_q)
                PH_CRST: begin
                    wait_q <= '0;
                    if (uv_flt) begin
                        hold_q <= '0;
                    end else if (hold_q == HW'(HOLD - 1)) begin
                        hold_q    <= '0;
                        phase_q   <= PH_RESYNC;
                        restart_q <= 1'b1;
                    end else begin
                        hold_q <= hold_q + 1'b1;
                    end
                end
                PH_RESYNC: begin
                    hold_q <= '0;
                    if (uv_flt) begin
                        wait_q  <= '0;
                        phase_q <= PH_CRST;
                    end else if (codec_lock) begin
                        wait_q  <= '0;
                        phase_q <= PH_RUN;
                    end else if (wait_q == TW'(TIMEOUT - 1)) begin
                        wait_q  <= '0;
                        phase_q <= PH_CRST;
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                PH_RUN: begin
                    hold_q <= '0;
                    wait_q <= '0;
                    if (uv_flt) begin
                        phase_q <= PH_CRST;
                    end
                end
                default: begin
                    phase_q <= PH_CRST;
                end
            endcase
        end
    end

    assign phase_o   = phase_q;
    assign restart_o = restart_q;

    // A filtered undervoltage always lands the sequencer in codec reset.
    p_uv_forces_crst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flt |=> (phase_q == PH_CRST));

    // Lock during resync without undervoltage starts playback.
    p_lock_unmute_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RESYNC && codec_lock && !uv_flt) |=> (phase_q == PH_RUN));

    // The restart pulse is one cycle wide.
    p_restart_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restart_q |=> !restart_q);

    // Resync is entered only from codec reset.
    p_resync_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RESYNC && $past(phase_q) != PH_RESYNC) |-> ($past(phase_q) == PH_CRST));

    // The lock-wait counter stays below its limit.
    p_wait_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wait_q < TW'(TIMEOUT));

endmodule

// File: rtl/rstmute_ctrl.sv
// Module: reset and mute controller (top).
// Does: combines the synchronized pin reset (deep reset, low power) with the
//       debounced brownout (codec-only reset) and drives the reset, restart
//       and mute outputs. The pin overrides everything else.
// Assumes: codec_lock is synchronous to clk; ext_rst_n and uv_detect are not.
module rstmute_ctrl
    import rstmute_pkg::*;
#(
    parameter int UV_DEBOUNCE  = 4,
    parameter int CODEC_HOLD   = 3,
    parameter int LOCK_TIMEOUT = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic ext_rst_n,
    input  logic uv_detect,
    input  logic codec_lock,
    output logic full_rst_n,
    output logic low_power,
    output logic codec_rst,
    output logic dsp_soft_rst,
    output logic dsp_restart,
    output logic dac_mute
);

    logic   rst_n_int;
    logic   uv_flt;
    phase_e phase;
    logic   restart;

    rstmute_rsync #(.STAGES(SYNC_STAGES)) u_rsync (
        .clk     (clk),
        .pin_n   (ext_rst_n),
        .rst_n_o (rst_n_int)
    );

    rstmute_uvfilt #(.DEPTH(UV_DEBOUNCE)) u_uvfilt (
        .clk    (clk),
        .rst_n  (rst_n_int),
        .uv_raw (uv_detect),
        .uv_flt (uv_flt)
    );

    rstmute_seq #(.HOLD(CODEC_HOLD), .TIMEOUT(LOCK_TIMEOUT)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n_int),
        .uv_flt     (uv_flt),
        .codec_lock (codec_lock),
        .phase_o    (phase),
        .restart_o  (restart)
    );

    // Purpose: output decode; the synchronized pin reset overrides every phase.
    always_comb begin
        full_rst_n   = rst_n_int;
        low_power    = !rst_n_int;
        codec_rst    = !rst_n_int || (phase == PH_CRST);
        dsp_soft_rst = !rst_n_int || (phase == PH_CRST);
        dsp_restart  = rst_n_int && restart;
        dac_mute     = !rst_n_int || (phase != PH_RUN);
    end

    // Pin low means the device is in low power with the codec reset and muted.
    p_pin_priority_r1: assert property (@(posedge clk)
        !ext_rst_n |-> (low_power && codec_rst && dac_mute && !dsp_restart));

    // Playback only happens when the codec is out of reset and the chip is released.
    p_mute_cover_r10: assert property (@(posedge clk) disable iff (!rst_n_int)
        !dac_mute |-> (!codec_rst && full_rst_n));

endmodule

// File: tb/rstmute_ctrl_bench.sv
module rstmute_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DEB        = 4;
    localparam int HOLD       = 3;
    localparam int TO         = 16;
    localparam int WATCHDOG   = 20000;

    logic clk        = 1'b0;
    logic ext_rst_n  = 1'b0;
    logic uv_detect  = 1'b0;
    logic codec_lock = 1'b0;
    logic full_rst_n, low_power, codec_rst, dsp_soft_rst, dsp_restart, dac_mute;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int cyc    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rstmute_ctrl #(
        .UV_DEBOUNCE(DEB), .CODEC_HOLD(HOLD), .LOCK_TIMEOUT(TO), .SYNC_STAGES(2)
    ) u_rstmute_ctrl (
        .clk(clk), .ext_rst_n(ext_rst_n), .uv_detect(uv_detect), .codec_lock(codec_lock),
        .full_rst_n(full_rst_n), .low_power(low_power), .codec_rst(codec_rst),
        .dsp_soft_rst(dsp_soft_rst), .dsp_restart(dsp_restart), .dac_mute(dac_mute)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // ---------------- behavioural reference model ----------------
    int m_pins  = 0;      // edges seen with the pin high (saturates at 2)
    int m_samp[$];        // synchronizer pipeline of uv samples, oldest first
    bit m_flt   = 0;
    int m_run   = 0;
    int m_phase = 0;      // 0 codec reset, 1 resync, 2 playing
    int m_hold  = 0;
    int m_wait  = 0;
    bit m_rst   = 0;

    always @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n) begin
            m_pins = 0; m_samp = {0, 0}; m_flt = 0; m_run = 0;
            m_phase = 0; m_hold = 0; m_wait = 0; m_rst = 0;
        end else begin
            if (m_pins < 2) begin
                m_samp = {0, 0}; m_flt = 0; m_run = 0;
                m_phase = 0; m_hold = 0; m_wait = 0; m_rst = 0;
            end else begin
                bit seen;
                bit old_flt;
                old_flt = m_flt;
                seen = m_samp[0];
                if (seen == m_flt) m_run = 0;
                else if (m_run == DEB - 1) begin m_flt = seen; m_run = 0; end
                else m_run++;
                m_samp.push_back(uv_detect);
                void'(m_samp.pop_front());
                m_rst = 0;
                if (m_phase == 0) begin
                    if (old_flt) m_hold = 0;
                    else if (m_hold == HOLD - 1) begin m_hold = 0; m_phase = 1; m_rst = 1; end
                    else m_hold++;
                end else if (m_phase == 1) begin
                    if (old_flt) begin m_phase = 0; m_wait = 0; end
                    else if (codec_lock) begin m_phase = 2; m_wait = 0; end
                    else if (m_wait == TO - 1) begin m_phase = 0; m_wait = 0; end
                    else m_wait++;
                end else begin
                    if (old_flt) m_phase = 0;
                end
            end
            if (m_pins < 2) m_pins++;
        end
    end

    // Every-cycle comparison against the model (R10 covers the mute relation).
    always @(negedge clk) begin
        if (!done) begin
            bit ok;
            ok = ext_rst_n && (m_pins >= 2);
            chk(full_rst_n == ok, "R2", "full_rst_n", full_rst_n, ok);
            chk(low_power == !ok, "R1", "low_power", low_power, !ok);
            chk(codec_rst == (!ok || m_phase == 0), "R4", "codec_rst", codec_rst, !ok || m_phase == 0);
            chk(dsp_soft_rst == (!ok || m_phase == 0), "R4", "dsp_soft_rst", dsp_soft_rst, !ok || m_phase == 0);
            chk(dsp_restart == (ok && m_rst), "R6", "dsp_restart", dsp_restart, ok && m_rst);
            chk(dac_mute == (!ok || m_phase != 2), "R10", "dac_mute", dac_mute, !ok || m_phase != 2);
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            chk(1'b0, "R10", "watchdog expired", cyc, WATCHDOG);
            finish_run();
        end
    end

    task automatic wait_restart(output int n);
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (!dsp_restart && n < 500);
    endtask

    initial begin
        int n;
        int base;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state while the pin is low
        chk(full_rst_n == 0 && low_power == 1, "R1", "deep reset outputs", {full_rst_n, low_power}, 1);
        chk(codec_rst && dsp_soft_rst && dac_mute && !dsp_restart, "R1", "codec/dsp/mute in reset",
            {codec_rst, dsp_soft_rst, dac_mute, dsp_restart}, 14);

        // R2: synchronous release after two edges
        @(posedge clk); #1 ext_rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(full_rst_n == 0, "R2", "released after one edge", full_rst_n, 0);
        @(posedge clk); @(negedge clk);
        chk(full_rst_n == 1 && low_power == 0, "R2", "released after two edges", full_rst_n, 1);
        wait_restart(n);
        base = n + 2;
        // R6: restart timing after the pin, mute held
        chk(base == 2 + HOLD, "R6", "edges to restart after pin", base, 2 + HOLD);
        chk(dac_mute == 1 && codec_rst == 0, "R6", "mute kept at restart", dac_mute, 1);

        // R7: lock during resync unmutes
        @(posedge clk); #1 codec_lock = 1'b1;
        @(negedge clk);
        chk(dac_mute == 1, "R7", "mute before lock sampled", dac_mute, 1);
        @(posedge clk); @(negedge clk);
        chk(dac_mute == 0, "R7", "unmute after lock", dac_mute, 0);

        // R3: a pulse one sample short is ignored
        @(posedge clk); #1 uv_detect = 1'b1;
        repeat (DEB - 1) @(posedge clk);
        #1 uv_detect = 1'b0;
        repeat (DEB + 6) @(negedge clk);
        chk(codec_rst == 0 && dac_mute == 0, "R3", "short dip ignored", {codec_rst, dac_mute}, 0);

        // R4: held brownout resets the codec only
        @(posedge clk); #1 uv_detect = 1'b1;
        repeat (DEB + 2) @(posedge clk);
        @(negedge clk);
        chk(codec_rst == 0, "R4", "codec_rst one edge early", codec_rst, 0);
        @(posedge clk); @(negedge clk);
        chk(codec_rst && dsp_soft_rst && dac_mute, "R4", "brownout reset", {codec_rst, dsp_soft_rst, dac_mute}, 7);
        chk(full_rst_n == 1 && low_power == 0, "R4", "deep reset untouched", full_rst_n, 1);

        // R5: recovery after brownout clears; codec loses lock
        repeat (20) @(posedge clk);
        #1 begin uv_detect = 1'b0; codec_lock = 1'b0; end
        repeat (DEB + 1 + HOLD) @(posedge clk);
        @(negedge clk);
        chk(codec_rst == 1, "R5", "codec reset still held", codec_rst, 1);
        @(posedge clk); @(negedge clk);
        chk(dsp_restart == 1, "R5", "restart after debounce and hold", dsp_restart, 1);

        // R8: no lock within the timeout re-enters codec reset
        repeat (TO - 1) @(posedge clk);
        @(negedge clk);
        chk(codec_rst == 0, "R8", "still resyncing", codec_rst, 0);
        @(posedge clk); @(negedge clk);
        chk(codec_rst == 1, "R8", "timeout reset", codec_rst, 1);

        // recover to playback
        @(posedge clk); #1 codec_lock = 1'b1;
        repeat (HOLD + 4) @(posedge clk);
        @(negedge clk);
        chk(dac_mute == 0, "R7", "playing after relock", dac_mute, 0);

        // R9: brownout during pin reset has no effect
        @(posedge clk); #1 ext_rst_n = 1'b0;
        #1;
        chk(full_rst_n == 0 && low_power && codec_rst && dac_mute, "R1", "async assertion",
            {full_rst_n, low_power, codec_rst, dac_mute}, 7);
        @(posedge clk); #1 uv_detect = 1'b1;
        repeat (DEB + 8) @(posedge clk);
        #1 uv_detect = 1'b0;
        repeat (DEB + 8) @(posedge clk);
        @(negedge clk);
        chk(full_rst_n == 0 && codec_rst && dac_mute && !dsp_restart, "R9", "held in pin reset",
            {full_rst_n, codec_rst, dac_mute, dsp_restart}, 6);
        @(posedge clk); #1 ext_rst_n = 1'b1;
        wait_restart(n);
        chk(n == base, "R9", "recovery same as baseline", n, base);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(dac_mute == 0, "R10", "unmuted after lock", dac_mute, 0);

        repeat (5) @(posedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule